// File: doc/BRIEF.md
# Parallel EPROM Read Cycle Controller

This block sits on the synchronous side of a chip and fetches single bytes from an external asynchronous EPROM. The EPROM has a 15-bit address bus, an 8-bit data bus and two active-low strobes. One strobe selects the device and the other gates its data onto the pins. A host raises `req` with an address while `busy` is low. The controller then drives the address and the select strobe, and lowers the output strobe only as late as the device allows. It captures the byte on the clock edge at which the access time has fully elapsed and returns it with a one-cycle `rvalid` pulse.

All timing comes from the speed grade and the clock period given as parameters. The grade is the address and select access time in nanoseconds. It also fixes the output-enable access time and the time the data pins take to float after release. Each of these times becomes a whole number of clock cycles, rounded up.

After a capture, both strobes rise together. The controller keeps `busy` high until the float time has passed, so the device's data pins are released before any other access drives the shared bus. A new request can be accepted in the last cycle of that gap, which is the earliest cycle the float time permits.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release with no request, `mem_ce_n` and `mem_oe_n` are 1, and `busy` and `rvalid` are 0.
- R2: The speed grade `SPEED_NS` gives the access time in ns. The output-enable time is 35 ns for grades up to 55, 40 ns for grades up to 90, and 50 ns above that. The float time is 25 ns for grades up to 90 and 30 ns above that. Each time is converted to cycles as ceil(time / `CLK_PERIOD_NS`), called ACC, OEC and FLT. With the defaults (20 ns, grade 55) these are ACC=3, OEC=2 and FLT=2; at grade 250 they are 13, 3 and 2.
- R3: A request is accepted on a rising edge where `req` is 1 and `busy` is 0. From that edge, `mem_addr` shows the request address and `mem_ce_n` is 0. `mem_addr` does not change while `mem_ce_n` is 0.
- R4: `mem_oe_n` falls ACC-OEC cycles after `mem_ce_n` falls and stays 0 for exactly OEC cycles. `mem_oe_n` is never 0 while `mem_ce_n` is 1.
- R5: `mem_ce_n` stays 0 for exactly ACC cycles. On the edge that ends them, the controller samples `mem_dq` into `rdata`, raises both strobes, and sets `rvalid` to 1 for exactly one cycle.
- R6: `rdata` keeps its value until the next capture.
- R7: After the strobes rise, `mem_ce_n` stays 1 for at least FLT cycles. `busy` stays 1 until the last of those cycles. A request held high is accepted in that cycle, which gives a strobe-high gap of exactly FLT cycles.
- R8: A request made while `busy` is 1 is ignored and is not queued. The address in progress, the captured byte and the strobes are unaffected, and no further access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Read request, sampled when `busy` is 0 |
| addr | input | 15 | Byte address of the request |
| busy | output | 1 | High while an access or float gap is in progress |
| rvalid | output | 1 | One-cycle pulse marking a fresh `rdata` |
| rdata | output | 8 | Captured byte |
| mem_addr | output | 15 | Address bus to the EPROM |
| mem_ce_n | output | 1 | Device select strobe, active low |
| mem_oe_n | output | 1 | Output gating strobe, active low |
| mem_dq | input | 8 | Data bus from the EPROM |

## Verification
If the cycle counter loads a wrong value or the sequencer takes a wrong transition, the lengths of the strobe-low windows are wrong. That shows on `mem_ce_n` and `mem_oe_n` during the same access, and a capture taken too early returns an invalid byte at the `rvalid` pulse of that read. A float-gap counter that is too short shows as `busy` falling early. A back-to-back read then lowers `mem_ce_n` again inside the float window, and the timed memory model in the bench reports this at that falling edge. A request leaking through while busy appears as an extra strobe cycle or a changed address within a few cycles of the original read.

// File: rtl/eprom_rd_pkg.sv
`timescale 1ns/1ps
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } rd_state_e;

    // Output-enable access time for a speed grade (ns).
    function automatic int oe_time_ns(input int grade_ns);
        if (grade_ns <= 55)      return 35;
        else if (grade_ns <= 90) return 40;
        else                     return 50;
    endfunction

    // Time for the data pins to float after strobe release (ns).
    function automatic int float_time_ns(input int grade_ns);
        return (grade_ns <= 90) ? 25 : 30;
    endfunction

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
`timescale 1ns/1ps
module eprom_rd_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/eprom_rd_seq.sv
`timescale 1ns/1ps
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int ADDR_W  = 15,
    parameter int CW      = 4,
    parameter int LAG_CYC = 1,
    parameter int OE_CYC  = 2,
    parameter int DF_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CW-1:0]     tmr_val,
    output logic              cap,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ce_n,
    output logic              oe_n
);
    localparam bit HAS_LAG = (LAG_CYC > 0);
    localparam bit HAS_GAP = (DF_CYC > 0);
    localparam logic [CW-1:0] LAG_LD = CW'(HAS_LAG ? LAG_CYC - 1 : 0);
    localparam logic [CW-1:0] OE_LD  = CW'((OE_CYC > 0) ? OE_CYC - 1 : 0);
    localparam logic [CW-1:0] DF_LD  = CW'(HAS_GAP ? DF_CYC - 1 : 0);

    typedef struct packed {
        rd_state_e         state;
        logic              ce_n;
        logic              oe_n;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_gap;

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        last_gap = (seq_q.state == ST_GAP) && tmr_zero;
        busy     = (seq_q.state != ST_IDLE) && !last_gap;

        case (seq_q.state)
            ST_IDLE, ST_GAP: begin
                if (!busy && req) begin
                    seq_d.addr = addr;
                    seq_d.ce_n = 1'b0;
                    tmr_load   = 1'b1;
                    if (HAS_LAG) begin
                        seq_d.state = ST_ADDR;
                        seq_d.oe_n  = 1'b1;
                        tmr_val     = LAG_LD;
                    end else begin
                        seq_d.state = ST_DATA;
                        seq_d.oe_n  = 1'b0;
                        tmr_val     = OE_LD;
                    end
                end else if (last_gap) begin
                    seq_d.state = ST_IDLE;
                end
            end
            ST_ADDR: begin
                if (tmr_zero) begin
                    seq_d.state = ST_DATA;
                    seq_d.oe_n  = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = OE_LD;
                end
            end
            ST_DATA: begin
                if (tmr_zero) begin
                    cap        = 1'b1;
                    seq_d.ce_n = 1'b1;
                    seq_d.oe_n = 1'b1;
                    if (HAS_GAP) begin
                        seq_d.state = ST_GAP;
                        tmr_load    = 1'b1;
                        tmr_val     = DF_LD;
                    end else begin
                        seq_d.state = ST_IDLE;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.ce_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
            seq_q.addr  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_addr = seq_q.addr;
    assign ce_n     = seq_q.ce_n;
    assign oe_n     = seq_q.oe_n;

    // R4
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.oe_n |-> !seq_q.ce_n);

    // R8
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> $stable(seq_q.addr));

endmodule

// File: rtl/eprom_rd_capture.sv
`timescale 1ns/1ps
module eprom_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] dq,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = cap;
        if (cap)
            cap_d.data = dq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q.valid <= 1'b0;
            cap_q.data  <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rvalid = cap_q.valid;
    assign rdata  = cap_q.data;

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/eprom_rd_ctrl.sv
`timescale 1ns/1ps
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int SPEED_NS      = 55,
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_dq
);
    localparam int ACC_CYC = ns_to_cycles(SPEED_NS, CLK_PERIOD_NS);
    localparam int OE_RAW  = ns_to_cycles(oe_time_ns(SPEED_NS), CLK_PERIOD_NS);
    localparam int OE_CYC  = (OE_RAW > ACC_CYC) ? ACC_CYC : OE_RAW;
    localparam int DF_CYC  = ns_to_cycles(float_time_ns(SPEED_NS), CLK_PERIOD_NS);
    localparam int LAG_CYC = ACC_CYC - OE_CYC;
    localparam int MAX_CYC = (ACC_CYC > DF_CYC) ? ACC_CYC : DF_CYC;
    localparam int CW      = $clog2(MAX_CYC + 2);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          cap;

    eprom_rd_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    eprom_rd_seq #(
        .ADDR_W  (ADDR_W),
        .CW      (CW),
        .LAG_CYC (LAG_CYC),
        .OE_CYC  (OE_CYC),
        .DF_CYC  (DF_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .addr     (addr),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .cap      (cap),
        .busy     (busy),
        .mem_addr (mem_addr),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n)
    );

    eprom_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap    (cap),
        .dq     (mem_dq),
        .rvalid (rvalid),
        .rdata  (rdata)
    );

    // Window counters observed at the pins, used only by the checks below.
    logic [CW-1:0] ce_run_q, oe_run_q, gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_run_q <= '0;
            oe_run_q <= '0;
            gap_q    <= CW'(DF_CYC);
        end else begin
            ce_run_q <= mem_ce_n ? '0 : ce_run_q + 1'b1;
            oe_run_q <= mem_oe_n ? '0 : oe_run_q + 1'b1;
            if (!mem_ce_n)
                gap_q <= '0;
            else if (gap_q < CW'(DF_CYC))
                gap_q <= gap_q + 1'b1;
        end
    end

    // R5
    acc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> (ce_run_q == CW'(ACC_CYC)));

    // R4
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_run_q == CW'(OE_CYC)));

    // R7
    float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (gap_q >= CW'(DF_CYC)));

    // R5
    valid_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ($rose(mem_ce_n) && mem_oe_n));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |=> (mem_ce_n || $stable(mem_addr)));

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> $stable(rdata));

    // R7
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_oe_n));

endmodule

// File: tb/eprom_model.sv
`timescale 1ns/1ps
module eprom_model #(
    parameter real T_ACC = 55.0,
    parameter real T_OE  = 35.0
) (
    input  logic [14:0] a,
    input  logic        ce_n,
    input  logic        oe_n,
    output logic [7:0]  dq
);
    realtime t_a  = 0.0;
    realtime t_ce = 0.0;
    realtime t_oe = 0.0;

    function automatic logic [7:0] content(input logic [14:0] x);
        return x[7:0] ^ {1'b0, x[14:8]} ^ 8'h3C;
    endfunction

    always @(a)          t_a  = $realtime;
    always @(negedge ce_n) t_ce = $realtime;
    always @(negedge oe_n) t_oe = $realtime;

    // Data is driven only once every access budget has elapsed; X otherwise.
    initial begin
        dq = 'x;
        #0.5;
        forever begin
            if (ce_n === 1'b0 && oe_n === 1'b0 &&
                ($realtime - t_a)  >= T_ACC - 0.5 &&
                ($realtime - t_ce) >= T_ACC - 0.5 &&
                ($realtime - t_oe) >= T_OE  - 0.5)
                dq = content(a);
            else
                dq = 'x;
            #1;
        end
    end

endmodule

// File: tb/eprom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_tb;
    // Expected cycle counts at 20 ns, derived from the grade rules.
    localparam int F_ACC = 3;   // 55 ns
    localparam int F_OE  = 2;   // 35 ns
    localparam int F_DF  = 2;   // 25 ns
    localparam int S_ACC = 13;  // 250 ns
    localparam int S_OE  = 3;   // 50 ns

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic req;
    logic [14:0] addr;
    logic busy, rvalid, mem_ce_n, mem_oe_n;
    logic [7:0] rdata, mem_dq;
    logic [14:0] mem_addr;

    logic s_req;
    logic [14:0] s_addr;
    logic s_busy, s_rvalid, s_ce_n, s_oe_n;
    logic [7:0] s_rdata, s_dq;
    logic [14:0] s_maddr;

    int total = 0;
    int bad   = 0;
    int f_viol = 0;
    int s_viol = 0;

    eprom_rd_ctrl #(.CLK_PERIOD_NS(20), .SPEED_NS(55)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy),
        .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dq(mem_dq)
    );
    eprom_model #(.T_ACC(55.0), .T_OE(35.0)) u_mem (
        .a(mem_addr), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .dq(mem_dq)
    );

    eprom_rd_ctrl #(.CLK_PERIOD_NS(20), .SPEED_NS(250)) u_dut_slow (
        .clk(clk), .rst_n(rst_n), .req(s_req), .addr(s_addr), .busy(s_busy),
        .rvalid(s_rvalid), .rdata(s_rdata), .mem_addr(s_maddr),
        .mem_ce_n(s_ce_n), .mem_oe_n(s_oe_n), .mem_dq(s_dq)
    );
    eprom_model #(.T_ACC(250.0), .T_OE(50.0)) u_mem_slow (
        .a(s_maddr), .ce_n(s_ce_n), .oe_n(s_oe_n), .dq(s_dq)
    );

    // Float-window monitors (R7).
    realtime f_rise = 0.0, s_rise = 0.0;
    always @(posedge mem_ce_n) f_rise = $realtime;
    always @(negedge mem_ce_n) if ($realtime - f_rise < 25.0) f_viol++;
    always @(posedge s_ce_n)   s_rise = $realtime;
    always @(negedge s_ce_n)   if ($realtime - s_rise < 30.0) s_viol++;

    function automatic logic [7:0] pat(input logic [14:0] x);
        return x[7:0] ^ {1'b0, x[14:8]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; req = 1'b0; addr = '0; s_req = 1'b0; s_addr = '0;
        repeat (3) @(negedge clk);
        chk(mem_ce_n === 1'b1 && mem_oe_n === 1'b1, "R1 strobes in reset",
            {mem_ce_n, mem_oe_n}, 2'b11);
        chk(busy === 1'b0 && rvalid === 1'b0, "R1 busy/rvalid in reset",
            {busy, rvalid}, 2'b00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && busy === 1'b0 && rvalid === 1'b0,
            "R1 idle after reset", {mem_ce_n, mem_oe_n, busy, rvalid}, 4'b1100);
    endtask

    task automatic test_read(input logic [14:0] a);
        int cyc = 0, ce_lo = 0, oe_lo = 0, lag = 0, bsy = 0;
        bit bad_strobe = 0;
        wait_idle();
        req = 1'b1; addr = a;
        @(negedge clk);
        req = 1'b0; addr = '0;
        chk(mem_addr === a && mem_ce_n === 1'b0, "R3 address and select driven",
            mem_addr, a);
        while (rvalid !== 1'b1 && cyc < 64) begin
            if (!mem_ce_n) ce_lo++;
            if (!mem_oe_n) oe_lo++;
            if (!mem_ce_n && mem_oe_n) lag++;
            if (mem_ce_n && !mem_oe_n) bad_strobe = 1;
            if (!mem_ce_n && mem_addr !== a) bad_strobe = 1;
            @(negedge clk);
            cyc++;
        end
        chk(cyc == F_ACC, "R5 capture latency", cyc, F_ACC);
        chk(ce_lo == F_ACC, "R2 select window", ce_lo, F_ACC);
        chk(oe_lo == F_OE, "R4 output-enable window", oe_lo, F_OE);
        chk(lag == F_ACC - F_OE, "R4 output-enable lag", lag, F_ACC - F_OE);
        chk(!bad_strobe, "R4 strobe order and address hold", bad_strobe, 0);
        chk(rdata === pat(a), "R5 captured byte", rdata, pat(a));
        chk(mem_ce_n === 1'b1 && mem_oe_n === 1'b1, "R5 strobes released",
            {mem_ce_n, mem_oe_n}, 2'b11);
        while (busy && bsy < 64) begin
            bsy++;
            @(negedge clk);
        end
        chk(bsy == F_DF - 1, "R7 busy during float gap", bsy, F_DF - 1);
        @(negedge clk);
        chk(rvalid === 1'b0 && rdata === pat(a), "R6 rdata held, pulse ended",
            rdata, pat(a));
    endtask

    task automatic test_busy_ignored(input logic [14:0] a, input logic [14:0] b);
        int cyc = 0;
        bit extra = 0;
        wait_idle();
        req = 1'b1; addr = a;
        @(negedge clk);
        addr = b;
        @(negedge clk);
        req = 1'b0; addr = '0;
        while (rvalid !== 1'b1 && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
        chk(rdata === pat(a), "R8 byte of first request kept", rdata, pat(a));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (mem_ce_n !== 1'b1 || rvalid !== 1'b0) extra = 1;
        end
        chk(!extra, "R8 no access started by busy request", extra, 0);
        chk(rdata === pat(a), "R8 rdata unchanged", rdata, pat(a));
    endtask

    task automatic test_back_to_back(input logic [14:0] a, input logic [14:0] b);
        int cyc = 0, hi = 0;
        wait_idle();
        req = 1'b1; addr = a;
        @(negedge clk);
        addr = b;
        while (rvalid !== 1'b1 && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
        chk(rdata === pat(a), "R5 first byte of burst", rdata, pat(a));
        while (mem_ce_n === 1'b1 && hi < 64) begin
            hi++;
            @(negedge clk);
        end
        req = 1'b0; addr = '0;
        chk(hi == F_DF, "R7 strobe-high gap between reads", hi, F_DF);
        chk(mem_addr === b, "R3 second address driven", mem_addr, b);
        cyc = 0;
        while (rvalid !== 1'b1 && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
        chk(rdata === pat(b), "R5 second byte of burst", rdata, pat(b));
    endtask

    task automatic test_slow(input logic [14:0] a);
        int cyc = 0, oe_lo = 0, lag = 0;
        @(negedge clk);
        while (s_busy) @(negedge clk);
        s_req = 1'b1; s_addr = a;
        @(negedge clk);
        s_req = 1'b0; s_addr = '0;
        while (s_rvalid !== 1'b1 && cyc < 64) begin
            if (!s_oe_n) oe_lo++;
            if (!s_ce_n && s_oe_n) lag++;
            @(negedge clk);
            cyc++;
        end
        chk(cyc == S_ACC, "R2 slow grade latency", cyc, S_ACC);
        chk(oe_lo == S_OE, "R2 slow output-enable window", oe_lo, S_OE);
        chk(lag == S_ACC - S_OE, "R4 slow output-enable lag", lag, S_ACC - S_OE);
        chk(s_rdata === pat(a), "R5 slow captured byte", s_rdata, pat(a));
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        test_reset();
        test_read(15'h0000);
        test_read(15'h7FFF);
        test_read(15'h5555);
        test_read(15'h2AAA);
        test_busy_ignored(15'h0123, 15'h4321);
        test_back_to_back(15'h1F0E, 15'h60A5);
        test_slow(15'h1234);
        test_slow(15'h7FFF);
        repeat (4) @(negedge clk);
        chk(f_viol == 0, "R7 fast float window respected", f_viol, 0);
        chk(s_viol == 0, "R7 slow float window respected", s_viol, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

endmodule